// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It runs on the converter clock. It accepts a start request that may arrive at any time, synchronizes it, and opens a sample strobe that lasts half a clock period. It then presents one trial code per clock to an external DAC, most significant bit first. The comparator answers each trial with a single bit, and the trial code converges on the held input.

The finished code goes into an output register. That register keeps the previous result for the whole of the next conversion and is rewritten only when the end-of-conversion flag rises. A new start request aborts any conversion in progress without touching the register. A read-enable input gates the result onto the data outputs. A 3-bit channel number is captured when the address strobe is first seen high.

Because the end-of-conversion flag drops as soon as a start request has been registered, the flag can be wired back to the start input to convert continuously. After reset, one forced start pulse is needed to set this loop going.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Right after reset, `conv_done_o` is 0, `sample_o` is 0, `trial_o` is 0, `result_o` is 0, `result_en_o` follows `read_en_i`, and `chan_sel_o` is 0.
- R2: While the synchronized start request is high, the conversion state is held cleared, so `trial_o` is 0. `conv_done_o` is low from the first falling clock edge after the request has been registered.
- R3: The start request is synchronized by two flops. `sample_o` rises on the third rising clock edge after `start_i` falls and falls on the next falling edge, so it is high for half a clock period. While it is high, `trial_o` is 0x80.
- R4: Bits are decided MSB first. `cmp_i` = 1 means the held input is at or above the current trial code, and that bit is kept. The final code is the largest code not above the held input, so it equals the held 8-bit input value.
- R5: `conv_done_o` rises on the ninth rising edge counted from the edge that opened sampling, which is the 11th rising edge after `start_i` falls. The result register is loaded on that same edge.
- R6: The result register keeps its previous value for the whole of a conversion until `conv_done_o` rises.
- R7: A start request during a conversion aborts it. `conv_done_o` stays low, the aborted code never reaches the result register, and the new conversion finishes with the R5 timing.
- R8: When `read_en_i` is 0, `result_en_o` is 0 and `result_o` reads 0. When it is 1, `result_en_o` is 1 and `result_o` carries the held result.
- R9: `chan_sel_o` takes `addr_i` on the first rising clock edge at which `addr_strobe_i` is high after being low. Address changes at any other time are ignored.
- R10: With `start_i` tied to `conv_done_o`, nothing happens after reset until a forced start pulse. After that pulse, conversions repeat with no further stimulus, and each one delivers the held input code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Asynchronous start request; high holds the sequence cleared |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above `trial_o` |
| addr_strobe_i | input | 1 | Channel address capture strobe |
| addr_i | input | 3 | Channel number to capture |
| read_en_i | input | 1 | Result read enable |
| sample_o | output | 1 | Half-period sample strobe for the sample-and-hold |
| trial_o | output | 8 | Trial code to the DAC |
| conv_done_o | output | 1 | End of conversion; high when the result is valid |
| chan_sel_o | output | 3 | Latched channel number |
| result_o | output | 8 | Held result, 0 when reads are disabled |
| result_en_o | output | 1 | High when `result_o` is driven (stands in for the tri-state enable) |

## Verification
Single conversions cover the all-zero and all-one codes, the codes on either side of the midpoint (0x80 and 0x7F), and an alternating pattern. The extremes show that every trial is rejected or every trial is kept. 0x7F and 0x80 separate an MSB decision that is wrong in only one direction. The alternating pattern catches an off-by-one in the bit index.

A restart issued partway through the bits separates an abort that leaks the partial code from one that leaves the result register untouched. Free-running operation with the flag fed back to the start input tests that the flag drops while a request is pending. The edge counts from the start release to the sample strobe and to the completion flag pin down the synchronizer depth and the half-period sample window.

// File: rtl/sar_adc_pkg.sv
// Shared types for the successive-approximation controller.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package sar_adc_pkg;

    // Phases of one conversion sequence.
    typedef enum logic [2:0] {
        PH_IDLE,    // after reset, no result yet
        PH_ARMED,   // start request held high, state cleared
        PH_SAMPLE,  // sample window open (first half) then MSB trial
        PH_BITS,    // remaining bit decisions
        PH_DONE     // result delivered, waiting for next request
    } sar_phase_e;

endpackage

// File: rtl/start_sync.sv
// Multi-flop synchronizer for the asynchronous start request.
// Assumes STAGES >= 2; the depth sets the start latency by whole clocks.
module start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/chan_latch.sv
// Captures the channel number on the first clock at which the address
// strobe is seen high after being low. Assumes the strobe lasts at least
// one clock and the address is steady while the strobe is high.
module chan_latch #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_i,
    input  logic [CH_W-1:0] addr_i,
    output logic [CH_W-1:0] chan_o
);

    logic strobe_q;
    logic capture;

    assign capture = strobe_i && !strobe_q;

    // Remember the strobe level and load the address on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            chan_o   <= '0;
        end else begin
            strobe_q <= strobe_i;
            if (capture) chan_o <= addr_i;
        end
    end

    assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && !strobe_q) |=> $stable(chan_o));

endmodule

// File: rtl/sar_engine.sv
// Sequencer and approximation register. It opens a half-clock sample
// window, resolves one bit per clock MSB first, and flags the final code.
// Assumes start_s is already synchronous to clk. The negative-edge flops
// shape the sample strobe and the completion flag to half-clock timing.
module sar_engine
    import sar_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_s,
    input  logic             cmp_i,
    output logic             sample_o,
    output logic [WIDTH-1:0] trial_o,
    output logic             done_o,
    output logic             load_o,
    output logic [WIDTH-1:0] code_o
);

    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH-1);

    sar_phase_e       phase_q;
    logic [WIDTH-1:0] sar_q;
    logic [WIDTH-1:0] sar_next;
    logic [IDX_W-1:0] idx_q;
    logic             deciding;
    logic             samp_seen_n;
    logic             busy_n;

    assign deciding = (phase_q == PH_SAMPLE) || (phase_q == PH_BITS);

    // Keep or drop the current trial bit and set up the next one.
    always_comb begin
        sar_next = sar_q;
        if (!cmp_i) sar_next[idx_q] = 1'b0;
        if (idx_q != '0) sar_next[idx_q - 1'b1] = 1'b1;
    end

    // Phase sequencing and register update on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sar_q   <= '0;
            idx_q   <= '0;
        end else if (start_s) begin
            phase_q <= PH_ARMED;
            sar_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_ARMED: begin
                    phase_q <= PH_SAMPLE;
                    sar_q   <= MSB_ONE;
                    idx_q   <= TOP_IDX;
                end
                PH_SAMPLE, PH_BITS: begin
                    sar_q <= sar_next;
                    if (idx_q == '0) begin
                        phase_q <= PH_DONE;
                    end else begin
                        phase_q <= PH_BITS;
                        idx_q   <= idx_q - 1'b1;
                    end
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

    // Falling-edge view of the phase: closes the sample window and lowers done.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            samp_seen_n <= 1'b0;
            busy_n      <= 1'b1;
        end else begin
            samp_seen_n <= (phase_q == PH_SAMPLE);
            busy_n      <= (phase_q != PH_DONE);
        end
    end

    assign sample_o = (phase_q == PH_SAMPLE) && !samp_seen_n;
    assign done_o   = (phase_q == PH_DONE) || !busy_n;
    assign trial_o  = sar_q;
    assign load_o   = deciding && (idx_q == '0) && !start_s;
    assign code_o   = sar_next;

    assert_trial_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_s |=> (trial_o == '0));

    assert_sample_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SAMPLE) |-> (trial_o == MSB_ONE));

    assert_done_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> done_o);

    assert_done_low_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BITS) |-> !done_o);

endmodule

// File: rtl/sar_adc_ctrl.sv
// Top level of the converter control logic: start synchronizer, sequencer,
// double-buffered result register with read gating, and channel latch.
// Assumes the analog parts (DAC, comparator, sample-and-hold, multiplexer)
// sit outside and that cmp_i settles within one clock of a trial change.
module sar_adc_ctrl #(
    parameter int WIDTH       = 8,
    parameter int CH_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             addr_strobe_i,
    input  logic [CH_W-1:0]  addr_i,
    input  logic             read_en_i,
    output logic             sample_o,
    output logic [WIDTH-1:0] trial_o,
    output logic             conv_done_o,
    output logic [CH_W-1:0]  chan_sel_o,
    output logic [WIDTH-1:0] result_o,
    output logic             result_en_o
);

    logic             start_s;
    logic             load;
    logic [WIDTH-1:0] code;
    logic [WIDTH-1:0] held_q;

    start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (start_i),
        .sync_o  (start_s)
    );

    sar_engine #(.WIDTH(WIDTH)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_s  (start_s),
        .cmp_i    (cmp_i),
        .sample_o (sample_o),
        .trial_o  (trial_o),
        .done_o   (conv_done_o),
        .load_o   (load),
        .code_o   (code)
    );

    chan_latch #(.CH_W(CH_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (addr_strobe_i),
        .addr_i   (addr_i),
        .chan_o   (chan_sel_o)
    );

    // Output buffer: written only when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= code;
    end

    assign result_en_o = read_en_i;
    assign result_o    = read_en_i ? held_q : '0;

    assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q));

    assert_load_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !conv_done_o);

endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_r = 1'b0;
    logic       fr_mode = 1'b0;
    logic       force_start = 1'b0;
    logic       strobe = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd_en = 1'b1;
    logic [7:0] analog = 8'd0;
    logic [7:0] held = 8'd0;

    logic       start_w;
    logic       cmp;
    logic       sample;
    logic [7:0] trial;
    logic       done;
    logic [2:0] chan;
    logic [7:0] result;
    logic       result_en;

    int  checks = 0;
    int  errors = 0;
    int  done_rises = 0;
    real rise_t = 0.0;
    real samp_width = 0.0;
    logic [7:0] exp_result = 8'd0;

    always #2.5 clk = ~clk;

    assign start_w = fr_mode ? (done | force_start) : start_r;
    assign cmp     = (held >= trial);

    // Behavioural sample-and-hold: the level at the close of the window.
    always @(negedge sample) held = analog;
    always @(posedge sample) rise_t = $realtime;
    always @(negedge sample) samp_width = $realtime - rise_t;
    always @(posedge done) done_rises++;

    sar_adc_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_w),
        .cmp_i         (cmp),
        .addr_strobe_i (strobe),
        .addr_i        (addr),
        .read_en_i     (rd_en),
        .sample_o      (sample),
        .trial_o       (trial),
        .conv_done_o   (done),
        .chan_sel_o    (chan),
        .result_o      (result),
        .result_en_o   (result_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int hold);
        @(negedge clk); #0.5;
        start_r = 1'b1;
        repeat (hold) @(negedge clk);
        #0.5;
        start_r = 1'b0;
    endtask

    // Counts rising edges after start release until done rises; checks the path.
    task automatic watch_conv(input string tag, input logic [7:0] want);
        int n = 0;
        int samp_at = 0;
        logic [7:0] trial_at_samp = 8'h00;
        logic buf_ok = 1'b1;
        while (!done && n < 40) begin
            @(posedge clk); #0.5;
            n++;
            if (sample && samp_at == 0) begin
                samp_at = n;
                trial_at_samp = trial;
            end
            if (!done && result !== exp_result) buf_ok = 1'b0;
        end
        chk({tag, " R3 sample opens on 3rd edge"}, samp_at, 3);
        chk({tag, " R3 trial 0x80 while sampling"}, trial_at_samp, 8'h80);
        chk({tag, " R3 sample width half period"}, $rtoi(samp_width * 10.0), 25);
        chk({tag, " R5 done on 11th edge"}, n, 11);
        chk({tag, " R6 result held during conversion"}, buf_ok, 1);
        chk({tag, " R4 final code"}, result, want);
        exp_result = want;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        @(posedge clk); #0.5;
        chk("R1 done low", done, 0);
        chk("R1 sample low", sample, 0);
        chk("R1 trial zero", trial, 0);
        chk("R1 result zero", result, 0);
        chk("R1 result enable", result_en, 1);
        chk("R1 channel zero", chan, 0);
        exp_result = 8'h00;
    endtask

    task automatic t_convert(input logic [7:0] val);
        analog = val;
        pulse_start(4);
        chk("R2 done low while start held", done, 0);
        chk("R2 trial cleared while start held", trial, 0);
        watch_conv("single", val);
    endtask

    task automatic t_restart;
        int base;
        base = done_rises;
        analog = 8'h3C;
        pulse_start(3);
        repeat (6) @(posedge clk);
        #0.5;
        chk("R7 mid-conversion done low", done, 0);
        analog = 8'hC4;
        pulse_start(3);
        chk("R7 done low after restart", done, 0);
        chk("R7 result untouched by abort", result, exp_result);
        watch_conv("restart", 8'hC4);
        chk("R7 single completion", done_rises - base, 1);
    endtask

    task automatic t_read_gate;
        @(negedge clk); #0.5;
        rd_en = 1'b0;
        #0.5;
        chk("R8 enable low", result_en, 0);
        chk("R8 bus reads zero", result, 0);
        rd_en = 1'b1;
        #0.5;
        chk("R8 enable high", result_en, 1);
        chk("R8 bus shows result", result, exp_result);
    endtask

    task automatic t_channel;
        @(negedge clk); #0.5;
        addr = 3'd5;
        strobe = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        strobe = 1'b0;
        addr = 3'd2;
        repeat (3) @(posedge clk);
        #0.5;
        chk("R9 captured channel", chan, 5);
        chk("R9 address change ignored", chan, 5);
        @(negedge clk); #0.5;
        strobe = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        strobe = 1'b0;
        @(posedge clk); #0.5;
        chk("R9 recapture channel", chan, 2);
    endtask

    task automatic t_free_run;
        int base;
        rst_n = 1'b0;
        fr_mode = 1'b1;
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        base = done_rises;
        repeat (20) @(posedge clk);
        #0.5;
        chk("R10 idle without forced pulse", done_rises - base, 0);
        chk("R10 done low without forced pulse", done, 0);
        analog = 8'h9A;
        @(negedge clk); #0.5;
        force_start = 1'b1;
        repeat (3) @(negedge clk);
        #0.5;
        force_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            int n = 0;
            while (done_rises < base + k + 1 && n < 60) begin
                @(posedge clk); #0.5;
                n++;
            end
            chk("R10 loop completed", (done_rises >= base + k + 1), 1);
            chk("R10 loop code", result, 8'h9A);
        end
        fr_mode = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(8'h00);
        t_convert(8'hFF);
        t_convert(8'h80);
        t_convert(8'h7F);
        t_convert(8'h55);
        t_restart();
        t_read_gate();
        t_channel();
        t_free_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule